// File: doc/BRIEF.md
# Rewindable FIFO Read Port

This block is the read-side controller of a synchronous FIFO. Each enabled read while data is present moves the word at the current read location into an output register and advances the read pointer. The write side, the flags beyond empty, and the storage array are outside the block. The array is reached through a read-address output and a combinational read-data input. The write pointer comes in already in the read clock domain.

The block can replay stored data. An active-low rewind request, sampled at a rising read-clock edge, returns the read pointer to location zero, so everything written since location zero becomes readable again. A latency strap chooses how the first replayed word appears. In zero-latency mode that word is in the output register straight after the edge that took the request. In normal mode the output register holds its value, and the first replayed word arrives on the next enabled read. The strap is captured only while master reset is held, and the read clock must run during reset for the capture to happen.

Top module: `rtxrd_read_port`

## Requirements
- R1: While master reset is low and right after it is released, `dout` is 0 and `rd_addr` is 0. `empty` is 1 when `wr_ptr` is 0.
- R2: The mode is taken from `lat_strap` on clock edges while `mrst_n` is low, where 0 means zero-latency and 1 means normal. Changing `lat_strap` after reset has no effect on how a rewind behaves.
- R3: An edge with `rd_en` high, `rtx_n` high and `empty` low loads `dout` with the word at `rd_addr` and advances the read pointer by one.
- R4: An edge with `rd_en` high while `empty` is high leaves `dout` and `rd_addr` unchanged.
- R5: An edge with `rtx_n` low rewinds the read pointer to location zero. While `rtx_n` is low, `rd_addr` presents 0.
- R6: In zero-latency mode with `wr_ptr` nonzero, the rewind edge loads `dout` with the word at location 0 and leaves the pointer at 1. The next enabled read returns the word at location 1.
- R7: In normal mode the rewind edge leaves `dout` unchanged. The next enabled read returns the word at location 0.
- R8: When `rtx_n` is low and `rd_en` is high at the same edge, the rewind is performed and the read is not.
- R9: `empty` is high exactly when the read pointer equals `wr_ptr`. This comparison uses one wrap bit above the address. After a rewind with `wr_ptr` nonzero, `empty` is low.
- R10: In zero-latency mode with `wr_ptr` equal to 0, a rewind leaves `dout` unchanged and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock, rising edge active |
| mrst_n | input | 1 | Master reset, active low, asynchronous for the pointer and output |
| lat_strap | input | 1 | Latency strap sampled during reset (0 zero-latency, 1 normal) |
| rd_en | input | 1 | Read enable |
| rtx_n | input | 1 | Rewind request, active low |
| wr_ptr | input | ADDR_W+1 | Write pointer with wrap bit, in the read clock domain |
| mem_rdata | input | DATA_W | Combinational read data from the array at `rd_addr` |
| rd_addr | output | ADDR_W | Array read address |
| dout | output | DATA_W | Output data register |
| empty | output | 1 | No unread data |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 16. Eight locations let it drain the whole stored run to empty within a few cycles and then rewind out of the empty state. Two master resets with opposite strap values bring both latency modes into one run. A strap change after each reset then shows that only the captured mode counts. Rewinds are issued both with and without a simultaneous read enable, and with a zero write pointer, to reach the priority and no-data cases.

// File: rtl/rtxrd_pkg.sv
package rtxrd_pkg;

   typedef enum logic {
      LAT_ZERO   = 1'b0,
      LAT_NORMAL = 1'b1
   } lat_mode_e;

endpackage

// File: rtl/rtxrd_mode_latch.sv
module rtxrd_mode_latch
   import rtxrd_pkg::*;
(
   input  logic      clk_rd,
   input  logic      mrst_n,
   input  logic      lat_strap,
   output lat_mode_e mode
);

   lat_mode_e mode_q;

   // Strap is captured on every clock edge while reset is held, frozen afterwards.
   always_ff @(posedge clk_rd) begin
      if (!mrst_n) mode_q <= lat_mode_e'(lat_strap);
   end

   assign mode = mode_q;

   p_mode_frozen_r2 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      mrst_n |=> $stable(mode_q));

endmodule

// File: rtl/rtxrd_ptr_ctrl.sv
module rtxrd_ptr_ctrl #(
   parameter int ADDR_W = 4,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              clk_rd,
   input  logic              mrst_n,
   input  logic              rtx_req,
   input  logic              rd_en,
   input  logic              zl_mode,
   input  logic [PTR_W-1:0]  wr_ptr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              empty,
   output logic              load_en
);

   localparam logic [PTR_W-1:0] PTR_ZERO = '0;
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] rd_ptr_nxt;
   logic             base_valid;

   assign base_valid = (wr_ptr != PTR_ZERO);
   assign empty      = (rd_ptr == wr_ptr);
   assign rd_addr    = rtx_req ? '0 : rd_ptr[ADDR_W-1:0];

   always_comb begin
      rd_ptr_nxt = rd_ptr;
      load_en    = 1'b0;
      if (rtx_req) begin
         if (zl_mode && base_valid) begin
            rd_ptr_nxt = PTR_ONE;
            load_en    = 1'b1;
         end else begin
            rd_ptr_nxt = PTR_ZERO;
         end
      end else if (rd_en && !empty) begin
         rd_ptr_nxt = rd_ptr + PTR_ONE;
         load_en    = 1'b1;
      end
   end

   always_ff @(posedge clk_rd or negedge mrst_n) begin
      if (!mrst_n) rd_ptr <= PTR_ZERO;
      else         rd_ptr <= rd_ptr_nxt;
   end

   p_rewind_normal_r5 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (rtx_req && !zl_mode) |=> (rd_ptr == PTR_ZERO));

   p_rewind_zl_r6 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (rtx_req && zl_mode && base_valid) |=> (rd_ptr == PTR_ONE));

   p_rewind_nodata_r10 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (rtx_req && !base_valid) |=> (rd_ptr == PTR_ZERO));

   p_step_r3 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (!rtx_req && rd_en && !empty) |=> (rd_ptr == $past(rd_ptr) + PTR_ONE));

   p_idle_empty_r4 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (!rtx_req && rd_en && empty) |=> $stable(rd_ptr));

endmodule

// File: rtl/rtxrd_out_reg.sv
module rtxrd_out_reg #(
   parameter int DATA_W = 18
) (
   input  logic              clk_rd,
   input  logic              mrst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] dout
);

   always_ff @(posedge clk_rd or negedge mrst_n) begin
      if (!mrst_n)      dout <= '0;
      else if (load_en) dout <= mem_rdata;
   end

   p_hold_r4 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      !load_en |=> $stable(dout));

endmodule

// File: rtl/rtxrd_read_port.sv
module rtxrd_read_port
   import rtxrd_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 18,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              clk_rd,
   input  logic              mrst_n,
   input  logic              lat_strap,
   input  logic              rd_en,
   input  logic              rtx_n,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] dout,
   output logic              empty
);

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr_w
      $error("rtxrd_read_port: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rtxrd_read_port: DATA_W must be positive");
   end

   lat_mode_e mode;
   logic      zl_mode;
   logic      rtx_req;
   logic      load_en;

   assign rtx_req = ~rtx_n;
   assign zl_mode = (mode == LAT_ZERO);

   rtxrd_mode_latch u_mode (
      .clk_rd    (clk_rd),
      .mrst_n    (mrst_n),
      .lat_strap (lat_strap),
      .mode      (mode)
   );

   rtxrd_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
      .clk_rd  (clk_rd),
      .mrst_n  (mrst_n),
      .rtx_req (rtx_req),
      .rd_en   (rd_en),
      .zl_mode (zl_mode),
      .wr_ptr  (wr_ptr),
      .rd_addr (rd_addr),
      .empty   (empty),
      .load_en (load_en)
   );

   rtxrd_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk_rd    (clk_rd),
      .mrst_n    (mrst_n),
      .load_en   (load_en),
      .mem_rdata (mem_rdata),
      .dout      (dout)
   );

   p_rewind_hold_r7 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (!rtx_n && mode == LAT_NORMAL) |=> $stable(dout));

   p_rewind_load_r6 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (!rtx_n && mode == LAT_ZERO && wr_ptr != '0) |=> (dout == $past(mem_rdata)));

   p_rewind_nonempty_r9 : assert property (@(posedge clk_rd) disable iff (!mrst_n)
      (!rtx_n && mode == LAT_NORMAL && $stable(wr_ptr) && wr_ptr != '0)
         |=> (!empty || wr_ptr != $past(wr_ptr)));

endmodule

// File: tb/test_rtxrd_read_port.sv
module test_rtxrd_read_port;

   localparam int ADDR_W = 3;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk_rd = 1'b0;
   logic              mrst_n = 1'b0;
   logic              lat_strap = 1'b1;
   logic              rd_en = 1'b0;
   logic              rtx_n = 1'b1;
   logic [ADDR_W:0]   wr_ptr = '0;
   logic [DATA_W-1:0] mem_rdata;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] dout;
   logic              empty;

   logic [DATA_W-1:0] mem [DEPTH];

   int n_chk  = 0;
   int n_fail = 0;

   logic [DATA_W-1:0] exp_q [$];
   string             tag_q [$];

   int                m_ptr;
   bit                m_zl;
   logic [DATA_W-1:0] m_dout;

   always #4 clk_rd = ~clk_rd;

   assign mem_rdata = mem[rd_addr];

   rtxrd_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rtxrd_read_port (
      .clk_rd    (clk_rd),
      .mrst_n    (mrst_n),
      .lat_strap (lat_strap),
      .rd_en     (rd_en),
      .rtx_n     (rtx_n),
      .wr_ptr    (wr_ptr),
      .mem_rdata (mem_rdata),
      .rd_addr   (rd_addr),
      .dout      (dout),
      .empty     (empty)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: compare dout against the scoreboard after each edge.
   always @(posedge clk_rd) begin
      #3;
      while (exp_q.size() > 0) begin
         logic [DATA_W-1:0] e;
         string             t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({t, " dout"}, 32'(dout), 32'(e));
      end
   end

   // Driver: one clock with the given controls; model computes expected state.
   task automatic cyc(input bit rd, input bit rtx, input string req);
      @(negedge clk_rd);
      rd_en = rd;
      rtx_n = !rtx;
      if (rtx) begin
         #1;
         check({req, " rd_addr during rewind (R5)"}, 32'(rd_addr), 32'd0);
      end
      if (rtx) begin
         if (m_zl && wr_ptr != 0) begin
            m_dout = mem[0];
            m_ptr  = 1;
         end else begin
            m_ptr = 0;
         end
      end else if (rd && m_ptr != int'(wr_ptr)) begin
         m_dout = mem[m_ptr % DEPTH];
         m_ptr  = (m_ptr + 1) % (2 * DEPTH);
      end
      @(posedge clk_rd);
      #1;
      rd_en = 1'b0;
      rtx_n = 1'b1;
      exp_q.push_back(m_dout);
      tag_q.push_back(req);
      #1;
      check({req, " rd_addr"}, 32'(rd_addr), 32'(m_ptr % DEPTH));
      check({req, " empty (R9)"}, 32'(empty), 32'(m_ptr == int'(wr_ptr)));
   endtask

   task automatic do_reset(input bit strap);
      @(negedge clk_rd);
      mrst_n    = 1'b0;
      lat_strap = strap;
      wr_ptr    = '0;
      #1;
      check("R1 dout in reset", 32'(dout), 32'd0);
      repeat (3) @(negedge clk_rd);
      m_zl   = !strap;
      m_ptr  = 0;
      m_dout = '0;
      mrst_n = 1'b1;
      #1;
      check("R1 dout after reset", 32'(dout), 32'd0);
      check("R1 rd_addr after reset", 32'(rd_addr), 32'd0);
      check("R1 empty after reset", 32'(empty), 32'd1);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(16'hA000 + i);

      // Normal-latency phase
      do_reset(1'b1);
      cyc(1, 0, "R4 read while empty");
      wr_ptr = 4'd5;
      cyc(1, 0, "R3 read 0");
      cyc(1, 0, "R3 read 1");
      cyc(1, 0, "R3 read 2");
      lat_strap = 1'b0;
      cyc(1, 1, "R8 R7 rewind with read, normal");
      cyc(1, 0, "R7 first replay");
      cyc(1, 0, "R7 second replay");
      cyc(1, 0, "R3 read 2 again");
      cyc(1, 0, "R3 read 3");
      cyc(1, 0, "R3 read 4");
      cyc(1, 0, "R4 read at empty");
      check("R9 drained empty", 32'(empty), 32'd1);
      cyc(0, 1, "R9 R2 rewind from empty");
      check("R9 nonempty after rewind", 32'(empty), 32'd0);
      cyc(1, 0, "R7 replay after drain");

      // Zero-latency phase
      do_reset(1'b0);
      cyc(0, 1, "R10 rewind with no data");
      wr_ptr = 4'd5;
      cyc(1, 0, "R3 zl read 0");
      cyc(1, 0, "R3 zl read 1");
      cyc(1, 1, "R8 R6 rewind with read, zero latency");
      cyc(1, 0, "R6 next after zl rewind");
      lat_strap = 1'b1;
      cyc(0, 1, "R2 R6 strap change ignored");
      cyc(1, 0, "R6 read after second rewind");
      wr_ptr = 4'd8;
      cyc(1, 0, "R3 read 2 full store");
      cyc(0, 1, "R6 R9 rewind with full store");

      repeat (2) @(negedge clk_rd);
      check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule